// File: doc/BRIEF.md
# Multi-Bit-Per-Clock CCITT CRC-16 Engine

This block keeps a running 16-bit cyclic redundancy remainder over a bit stream. It uses the generator polynomial x^16 + x^12 + x^5 + 1. Each clock it can take a word of `LANES` bits, where `LANES` is a parameter from 1 to 16. The one-bit shift-register step is applied `LANES` times within one cycle, through a purely combinational XOR chain that is built at elaboration time. The design uses no lookup table and no iteration over several cycles.

The register bits are named c0 to c15, and c0 is the most significant. The data moves from the high index toward c0. On the output port, c_i appears on `crc_o[15-i]`. Inside a data word, the most significant bit is the first bit into the register.

A synchronous reset loads the register with the parameter `PRESET`, which is all ones by default. A clear strobe also loads `PRESET`, so a new message can start. When the valid strobe is low, the register holds its value. The output is the raw remainder: it is neither inverted nor bit-reversed.

Top module: `crc16_stream_engine`

## Requirements
- R1: In one serial step with input bit d, the feedback value f = c0 XOR d. The step then loads f into c15, loads c11 XOR f into c10, and loads c4 XOR f into c3. Every other ci takes c(i+1). The output bit `crc_o[15-i]` carries ci.
- R2: A cycle with `valid_i` high and `clr_i` low updates the register to the result of `LANES` serial steps. The steps use `data_i[LANES-1]` first and `data_i[0]` last.
- R3: While `rst` is high at a rising edge, the register loads `PRESET` (default 16'hFFFF). Reset wins over clear and valid.
- R4: `clr_i` high at an edge loads `PRESET` even when `valid_i` is high. The data word presented in that cycle has no effect.
- R5: `valid_i` low with `clr_i` low leaves the register unchanged, whatever is on `data_i`.
- R6: With `LANES` = 8 and an all-ones preset, feeding the ASCII bytes "123456789" in order leaves the register at 16'h29B1.
- R7: The remainder depends only on the bit stream, not on the word width. Instances with `LANES` of 1, 8 and 16 that are fed the same bits agree at every 16-bit boundary.
- R8: A register at zero stays at zero when it is fed a valid all-zero word. A 16-lane word equal to the current remainder drives the register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, loads PRESET |
| clr_i | input | 1 | Start-of-message clear, loads PRESET |
| valid_i | input | 1 | Data word valid strobe |
| data_i | input | LANES | Data word, most significant bit applied first |
| crc_o | output | 16 | Current remainder, c0 on bit 15 |

## Verification
The bench runs three widths (1, 8 and 16 lanes) against a bit-at-a-time reference model over random streams with random gaps and clears. A reversed order of the bits within a word, or a tap placed on the wrong bit, shows up as a mismatch against the model within a few words. At each 16-bit boundary the three widths must agree, and "123456789" must give 0x29B1. A clear that fails to override valid would fold the data of that cycle into the preset. Failing to hold when valid is low would change the remainder on idle cycles. The zero-remainder case catches a network that leaks the old remainder into the result instead of cancelling it.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
    localparam int CRC_W = 16;
    // x^12, x^5 and x^0 terms in conventional bit order (c0 is bit 15)
    localparam logic [CRC_W-1:0] GEN_TAPS = 16'h1021;

    typedef struct packed {
        logic [CRC_W-1:0] rem;
    } crc_state_t;
endpackage

// File: rtl/crc16_serial_stage.sv
module crc16_serial_stage
    import crc16_pkg::*;
(
    input  logic [CRC_W-1:0] rem_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] rem_o
);
    logic fb;

    always_comb begin
        fb    = rem_i[CRC_W-1] ^ bit_i;
        rem_o = {rem_i[CRC_W-2:0], 1'b0} ^ (GEN_TAPS & {CRC_W{fb}});
    end
endmodule

// File: rtl/crc16_unroll.sv
module crc16_unroll
    import crc16_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [CRC_W-1:0] rem_i,
    input  logic [LANES-1:0] data_i,
    output logic [CRC_W-1:0] rem_o
);
    logic [CRC_W-1:0] chain [0:LANES];

    assign chain[0] = rem_i;

    for (genvar k = 0; k < LANES; k++) begin : g_stage
        crc16_serial_stage u_stage (
            .rem_i (chain[k]),
            .bit_i (data_i[LANES-1-k]),
            .rem_o (chain[k+1])
        );
    end

    assign rem_o = chain[LANES];
endmodule

// File: rtl/crc16_stream_engine.sv
module crc16_stream_engine
    import crc16_pkg::*;
#(
    parameter int               LANES  = 8,
    parameter logic [15:0]      PRESET = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             valid_i,
    input  logic [LANES-1:0] data_i,
    output logic [15:0]      crc_o
);
    crc_state_t       state_d, state_q;
    logic [CRC_W-1:0] advanced;

    crc16_unroll #(.LANES(LANES)) u_net (
        .rem_i  (state_q.rem),
        .data_i (data_i),
        .rem_o  (advanced)
    );

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d.rem = PRESET;
        end else if (valid_i) begin
            state_d.rem = advanced;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.rem <= PRESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign crc_o = state_q.rem;
endmodule

// File: rtl/crc16_chk.sv
module crc16_chk #(
    parameter int          LANES  = 8,
    parameter logic [15:0] PRESET = 16'hFFFF
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_i,
    input logic             valid_i,
    input logic [LANES-1:0] data_i,
    input logic [15:0]      crc_o
);
    a_r3_reset_preset: assert property (@(posedge clk)
        rst |=> crc_o == PRESET);

    a_r4_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> crc_o == PRESET);

    a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !valid_i) |=> $stable(crc_o));

    a_r8_zero_stays: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !clr_i && data_i == '0 && crc_o == 16'h0000) |=> crc_o == 16'h0000);

    if (LANES == 1) begin : g_serial
        // R1: c15 (bit 0) receives c0 XOR d
        a_r1_tail_feedback: assert property (@(posedge clk) disable iff (rst)
            (valid_i && !clr_i) |=> crc_o[0] == ($past(crc_o[15]) ^ $past(data_i[0])));
        // R1: c14 (bit 1) receives c15 unchanged
        a_r1_plain_shift: assert property (@(posedge clk) disable iff (rst)
            (valid_i && !clr_i) |=> crc_o[1] == $past(crc_o[0]));
    end
endmodule

bind crc16_stream_engine crc16_chk #(.LANES(LANES), .PRESET(PRESET)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr_i),
    .valid_i (valid_i),
    .data_i  (data_i),
    .crc_o   (crc_o)
);

// File: tb/sim_crc16_stream_engine.sv
module sim_crc16_stream_engine;
    localparam int PERIOD = 10;
    localparam logic [15:0] PRE = 16'hFFFF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic c1 = 1'b0, v1 = 1'b0; logic [0:0]  d1 = '0;
    logic c8 = 1'b0, v8 = 1'b0; logic [7:0]  d8 = '0;
    logic c16 = 1'b0, v16 = 1'b0; logic [15:0] d16 = '0;
    logic [15:0] q1, q8, q16;

    always #(PERIOD/2) clk = ~clk;

    crc16_stream_engine #(.LANES(8),  .PRESET(PRE)) u0 (.clk(clk), .rst(rst), .clr_i(c8),  .valid_i(v8),  .data_i(d8),  .crc_o(q8));
    crc16_stream_engine #(.LANES(1),  .PRESET(PRE)) u1 (.clk(clk), .rst(rst), .clr_i(c1),  .valid_i(v1),  .data_i(d1),  .crc_o(q1));
    crc16_stream_engine #(.LANES(16), .PRESET(PRE)) u2 (.clk(clk), .rst(rst), .clr_i(c16), .valid_i(v16), .data_i(d16), .crc_o(q16));

    typedef struct {
        logic [15:0] e1, e8, e16;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] m1 = PRE, m8 = PRE, m16 = PRE;
    int          checks = 0, fails = 0;

    // reference: R1 serial step, c0 on bit 15
    function automatic logic [15:0] ref_bit(logic [15:0] c, logic d);
        logic [15:0] n;
        logic f;
        f = c[15] ^ d;
        for (int i = 0; i < 15; i++) n[15-i] = c[15-(i+1)];
        n[0]  = f;
        n[5]  = c[4]  ^ f;
        n[12] = c[11] ^ f;
        return n;
    endfunction

    function automatic logic [15:0] ref_word(logic [15:0] c, logic [15:0] w, int n);
        logic [15:0] r;
        r = c;
        for (int k = n - 1; k >= 0; k--) r = ref_bit(r, w[k]);
        return r;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic r,
                         logic cl1, logic va1, logic b1,
                         logic cl8, logic va8, logic [7:0] b8,
                         logic cl16, logic va16, logic [15:0] b16);
        exp_t e;
        @(negedge clk);
        rst = r;
        c1 = cl1; v1 = va1; d1 = b1;
        c8 = cl8; v8 = va8; d8 = b8;
        c16 = cl16; v16 = va16; d16 = b16;
        if (r || cl1) m1 = PRE; else if (va1) m1 = ref_word(m1, {15'd0, b1}, 1);
        if (r || cl8) m8 = PRE; else if (va8) m8 = ref_word(m8, {8'd0, b8}, 8);
        if (r || cl16) m16 = PRE; else if (va16) m16 = ref_word(m16, b16, 16);
        e.e1 = m1; e.e8 = m8; e.e16 = m16;
        sb.push_back(e);
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0000);
    endtask

    task automatic settle();
        @(posedge clk);
        #(PERIOD/4);
    endtask

    // monitor: scoreboard against R2 reference model
    initial begin
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check("R2 u1", q1, e.e1);
                check("R2 u0", q8, e.e8);
                check("R2 u2", q16, e.e16);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=running exp=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] hold8;
        logic [7:0]  msg [9];
        // R3: reset state
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b1, 16'h1234);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0000);
        settle();
        check("R3 u0 reset", q8, PRE);
        check("R3 u2 reset", q16, PRE);

        // random streams with gaps and clears (R2, R5)
        for (int i = 0; i < 400; i++) begin
            drive(1'b0,
                  ($urandom_range(0, 29) == 0), ($urandom_range(0, 3) != 0), 1'($urandom),
                  ($urandom_range(0, 29) == 0), ($urandom_range(0, 3) != 0), 8'($urandom),
                  ($urandom_range(0, 29) == 0), ($urandom_range(0, 3) != 0), 16'($urandom));
        end

        // R5: valid low, data toggling, value held
        idle();
        settle();
        hold8 = q8;
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 16'hFFFF);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0, 16'h0F0F);
        settle();
        check("R5 u0 hold", q8, hold8);

        // R4: clear together with valid drops the data
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b1, 16'hBEEF);
        settle();
        check("R4 u0 clear", q8, PRE);
        check("R4 u1 clear", q1, PRE);
        check("R4 u2 clear", q16, PRE);

        // R6: check string on u0 and bit-serially on u1
        msg = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        for (int b = 0; b < 9; b++) begin
            for (int k = 7; k >= 0; k--) begin
                drive(1'b0, 1'b0, 1'b1, msg[b][k],
                      1'b0, (k == 7), msg[b],
                      1'b0, 1'b0, 16'h0000);
            end
        end
        idle();
        settle();
        check("R6 u0 check string", q8, 16'h29B1);
        check("R6 u1 check string", q1, 16'h29B1);

        // R7: same stream into all widths, compare at 16-bit boundaries
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0000);
        for (int w = 0; w < 6; w++) begin
            logic [15:0] word;
            word = 16'($urandom);
            for (int k = 15; k >= 0; k--) begin
                drive(1'b0, 1'b0, 1'b1, word[k],
                      1'b0, (k == 15 || k == 7), (k == 15) ? word[15:8] : word[7:0],
                      1'b0, (k == 15), word);
            end
            idle();
            settle();
            check("R7 u0 vs u1", q8, q1);
            check("R7 u2 vs u1", q16, q1);
        end

        // R8: cancel the remainder, then zero data keeps it zero
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, m16);
        settle();
        check("R8 u2 cancel", q16, 16'h0000);
        for (int i = 0; i < 3; i++)
            drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 16'h0000);
        settle();
        check("R8 u2 zero hold", q16, 16'h0000);

        // R1: single serial step from preset with d=0 on u1
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0000);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0000);
        settle();
        check("R1 u1 one step", q1, 16'hEFDF);

        // R3: reset mid-stream
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h77, 1'b0, 1'b1, 16'h7777);
        settle();
        check("R3 u0 midstream reset", q8, PRE);

        idle();
        idle();
        settle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule